// File: doc/BRIEF.md
# Three-Level Clamped Leg Gate Sequencer

This block produces the four gate drives for one leg of a three-level neutral-point-clamped converter. A modulator upstream asks for one of three output levels: the positive rail, the clamped midpoint or the negative rail. The sequencer moves the leg toward that level one adjacent step at a time. Each step opens a blanking window in which both switches of the complementary pair being handed over are held off. Only then does the incoming switch turn on.

The outer upper switch S1 pairs with the inner lower switch S3, and the inner upper switch S2 pairs with the outer lower switch S4. A request that crosses from one rail to the other is split into two steps through the clamped level. Each level that is reached is kept for at least the blanking time before the next step may start. The blanking length is a cycle count supplied on a port. It is sampled when each step begins.

Top module: `npc_leg_seq`

## Requirements
- R1: While reset is asserted, and after reset for as long as the request is the hold code 11, all four gates are off (gate_o = 0000).
- R2: Gate bit 0 drives S1 (outer upper), bit 1 drives S2 (inner upper), bit 2 drives S3 (inner lower) and bit 3 drives S4 (outer lower). A settled positive level (request code 01) gives 0011, the clamped level (request code 00) gives 0110, and the negative level (request code 10) gives 1100.
- R3: From the all-off state, the first non-hold request of any kind moves the gates to 0110 on the next clock edge, with no blanking window.
- R4: S1 and S3 are never on together, and S2 and S4 are never on together.
- R5: No gate turns on in the same cycle that another turns off. Between positive and clamped levels only S2 is on during blanking (0010). Between clamped and negative levels only S3 is on (0100).
- R6: A blanking window lasts exactly blank_cyc cycles, or one cycle when blank_cyc is 0. The count is sampled on the edge that opens the window, and changing blank_cyc later does not alter that window.
- R7: A level that has been reached is held for at least as many cycles as the last sampled blanking count before the next step starts.
- R8: The gates only show the patterns 0000, 0110, 0011, 1100, 0010 and 0100, and at most one gate changes per cycle, except for the single 0000 to 0110 entry. A move between the two rails always passes through 0110.
- R9: Request code 11 keeps the current level unchanged and lets a window already in progress complete.
- R10: A blanking window, once opened, always completes into the level it was heading for, even if the request changes during the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_state | input | 2 | Requested level: 00 clamped, 01 positive, 10 negative, 11 hold |
| blank_cyc | input | CNT_W | Blanking length in clock cycles (0 treated as 1) |
| gate_o | output | 4 | Gate drives, bit 0 = S1 through bit 3 = S4 |

## Verification
The bench aims at the rail-to-rail request. A design that took a shortcut would drop S2 and raise S4 in one step, or skip the dwell at the clamped level. It measures each blanking and dwell run against the sampled count. A zero count must still give a one-cycle gap. A count changed in the middle of a window must leave that window's length unchanged, and a design that read the count live would cut the gap short. It also reverses the request inside a window, which would expose a design that aborts mid-handover and leaves the leg on an illegal pattern. Random requests and counts are then compared every cycle with a behavioural model.

// File: rtl/npc_leg_pkg.sv
package npc_leg_pkg;

   typedef enum logic [1:0] {
      LV_OFF  = 2'd0,
      LV_MID  = 2'd1,
      LV_HIGH = 2'd2,
      LV_LOW  = 2'd3
   } leg_lvl_t;

   localparam logic [1:0] REQ_MID  = 2'b00;
   localparam logic [1:0] REQ_HIGH = 2'b01;
   localparam logic [1:0] REQ_LOW  = 2'b10;
   localparam logic [1:0] REQ_HOLD = 2'b11;

   localparam int NUM_GATES = 4;

   function automatic logic [NUM_GATES-1:0] lvl_mask(leg_lvl_t l);
      case (l)
         LV_HIGH: lvl_mask = 4'b0011;
         LV_MID:  lvl_mask = 4'b0110;
         LV_LOW:  lvl_mask = 4'b1100;
         default: lvl_mask = 4'b0000;
      endcase
   endfunction

   function automatic leg_lvl_t req_to_lvl(logic [1:0] code, leg_lvl_t cur);
      case (code)
         REQ_MID:  req_to_lvl = LV_MID;
         REQ_HIGH: req_to_lvl = LV_HIGH;
         REQ_LOW:  req_to_lvl = LV_LOW;
         default:  req_to_lvl = cur;
      endcase
   endfunction

endpackage

// File: rtl/npc_step_planner.sv
module npc_step_planner
   import npc_leg_pkg::*;
(
   input  leg_lvl_t   cur_lvl,
   input  logic [1:0] req_code,
   output logic       want_step,
   output leg_lvl_t   step_lvl
);
   leg_lvl_t goal;

   always_comb begin
      goal      = req_to_lvl(req_code, cur_lvl);
      want_step = 1'b0;
      step_lvl  = cur_lvl;
      if (cur_lvl == LV_OFF) begin
         if (req_code != REQ_HOLD) begin
            want_step = 1'b1;
            step_lvl  = LV_MID;
         end
      end else if (goal != cur_lvl) begin
         want_step = 1'b1;
         step_lvl  = (cur_lvl == LV_MID) ? goal : LV_MID;
      end
   end
endmodule

// File: rtl/npc_hold_timer.sv
module npc_hold_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;

   assign expired = (count_q >= (limit - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (restart) count_q <= '0;
      else if (!expired) count_q <= count_q + ONE;
   end
endmodule

// File: rtl/npc_gate_map.sv
module npc_gate_map
   import npc_leg_pkg::*;
(
   input  leg_lvl_t               lvl,
   input  leg_lvl_t               tgt,
   input  logic                   blanking,
   output logic [NUM_GATES-1:0]   gates
);
   logic [NUM_GATES-1:0] from_mask;
   logic [NUM_GATES-1:0] to_mask;

   assign from_mask = lvl_mask(lvl);
   assign to_mask   = lvl_mask(tgt);

   for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_gate
      assign gates[gi] = from_mask[gi] & (~blanking | to_mask[gi]);
   end
endmodule

// File: rtl/npc_leg_seq.sv
module npc_leg_seq
   import npc_leg_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       req_state,
   input  logic [CNT_W-1:0] blank_cyc,
   output logic [3:0]       gate_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
      $error("npc_leg_seq: CNT_W must lie in 1..16");
   end
   if (NUM_GATES != 4) begin : g_bad_gates
      $error("npc_leg_seq: a three-level leg has four gates");
   end

   leg_lvl_t         cur_q, cur_d;
   leg_lvl_t         tgt_q, tgt_d;
   logic             blank_q, blank_d;
   logic [CNT_W-1:0] blk_q, blk_d;
   logic [CNT_W-1:0] eff_blank;
   logic             restart;
   logic             expired;
   logic             want_step;
   leg_lvl_t         step_lvl;
   logic [3:0]       gate_d;

   assign eff_blank = (blank_cyc == '0) ? ONE : blank_cyc;

   npc_step_planner u_plan (
      .cur_lvl   (cur_q),
      .req_code  (req_state),
      .want_step (want_step),
      .step_lvl  (step_lvl)
   );

   npc_hold_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (blk_q),
      .expired (expired)
   );

   always_comb begin
      cur_d   = cur_q;
      tgt_d   = tgt_q;
      blank_d = blank_q;
      blk_d   = blk_q;
      restart = 1'b0;
      if (blank_q) begin
         if (expired) begin
            cur_d   = tgt_q;
            blank_d = 1'b0;
            restart = 1'b1;
         end
      end else if (want_step) begin
         if (cur_q == LV_OFF) begin
            cur_d   = LV_MID;
            blk_d   = eff_blank;
            restart = 1'b1;
         end else if (expired) begin
            tgt_d   = step_lvl;
            blank_d = 1'b1;
            blk_d   = eff_blank;
            restart = 1'b1;
         end
      end
   end

   npc_gate_map u_map (
      .lvl      (cur_d),
      .tgt      (tgt_d),
      .blanking (blank_d),
      .gates    (gate_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= LV_OFF;
         tgt_q   <= LV_OFF;
         blank_q <= 1'b0;
         blk_q   <= ONE;
         gate_o  <= '0;
      end else begin
         cur_q   <= cur_d;
         tgt_q   <= tgt_d;
         blank_q <= blank_d;
         blk_q   <= blk_d;
         gate_o  <= gate_d;
      end
   end
endmodule

// File: rtl/npc_leg_seq_chk.sv
module npc_leg_seq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       req_state,
   input logic [CNT_W-1:0] blank_cyc,
   input logic [3:0]       gate_o
);
   localparam logic [CNT_W:0] RUN_MAX = {(CNT_W+1){1'b1}};

   logic             single_now, steady_now;
   logic             was_single, was_steady;
   logic [3:0]       prev_g;
   logic [CNT_W-1:0] prev_blank;
   logic [CNT_W:0]   lim_q, run_blank, run_hold;
   logic [CNT_W:0]   eff_prev;

   assign single_now = (gate_o == 4'b0010) || (gate_o == 4'b0100);
   assign steady_now = (gate_o == 4'b0011) || (gate_o == 4'b0110) || (gate_o == 4'b1100);
   assign eff_prev   = (prev_blank == '0) ? (CNT_W+1)'(1) : {1'b0, prev_blank};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_single <= 1'b0;
         was_steady <= 1'b0;
         prev_g     <= '0;
         prev_blank <= '0;
         lim_q      <= (CNT_W+1)'(1);
         run_blank  <= '0;
         run_hold   <= '0;
      end else begin
         was_single <= single_now;
         was_steady <= steady_now;
         prev_g     <= gate_o;
         prev_blank <= blank_cyc;
         if (single_now && !was_single) begin
            run_blank <= (CNT_W+1)'(1);
            lim_q     <= eff_prev;
         end else if (single_now && run_blank != RUN_MAX) begin
            run_blank <= run_blank + 1'b1;
         end
         if (gate_o == 4'b0110 && prev_g == 4'b0000)
            lim_q <= eff_prev;
         if (steady_now && gate_o != prev_g)
            run_hold <= (CNT_W+1)'(1);
         else if (steady_now && run_hold != RUN_MAX)
            run_hold <= run_hold + 1'b1;
      end
   end

   p_reset_off_r1: assert property (@(posedge clk) !rst_n |-> gate_o == 4'b0000);

   p_pair_s1s3_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[0] && gate_o[2]));

   p_pair_s2s4_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[1] && gate_o[3]));

   p_break_make_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_o & ~prev_g) != 4'b0000) |-> ((prev_g & ~gate_o) == 4'b0000));

   p_blank_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (was_single && !single_now) |-> (run_blank == lim_q));

   p_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (was_steady && single_now) |-> (run_hold >= lim_q));

   p_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      single_now || steady_now || gate_o == 4'b0000);

   p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(gate_o ^ prev_g) <= 1) || (prev_g == 4'b0000 && gate_o == 4'b0110));

   p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_g == 4'b0000 && $past(req_state) == 2'b11) |-> gate_o == 4'b0000);

endmodule

bind npc_leg_seq npc_leg_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_state (req_state),
   .blank_cyc (blank_cyc),
   .gate_o    (gate_o)
);

// File: tb/npc_leg_seq_tb.sv
module npc_leg_seq_tb;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       req_state = 2'b11;
   logic [CNT_W-1:0] blank_cyc = '0;
   logic [3:0]       gate_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   npc_leg_seq #(.CNT_W(CNT_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_state (req_state),
      .blank_cyc (blank_cyc),
      .gate_o    (gate_o)
   );

   // behavioural reference: 0 off, 1 mid, 2 high, 3 low
   int m_lvl = 0, m_to = 0, m_left = 0, m_win = 1;
   bit m_blank = 0;

   function automatic logic [3:0] m_gates(int lvl, int to, bit blank);
      if (blank) return (lvl == 2 || to == 2) ? 4'b0010 : 4'b0100;
      case (lvl)
         1: return 4'b0110;
         2: return 4'b0011;
         3: return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl = 0; m_blank = 0; m_left = 0; m_to = 0; m_win = 1;
      end else begin
         int beff, want;
         beff = (blank_cyc == 0) ? 1 : int'(blank_cyc);
         want = (req_state == 2'b00) ? 1 : (req_state == 2'b01) ? 2 :
                (req_state == 2'b10) ? 3 : m_lvl;
         if (m_blank) begin
            if (m_left == 0) begin
               m_lvl = m_to; m_blank = 0; m_left = m_win - 1;
            end else m_left--;
         end else if (m_lvl == 0) begin
            if (req_state != 2'b11) begin
               m_lvl = 1; m_win = beff; m_left = beff - 1;
            end
         end else if (m_left > 0) begin
            m_left--;
         end else if (want != m_lvl) begin
            m_to = (m_lvl == 1) ? want : 1;
            m_blank = 1; m_win = beff; m_left = beff - 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [3:0] act,
                        input logic [3:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_int(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // every cycle: model comparison (R2, R5, R8) and pair exclusion (R4)
   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] e;
         e = m_gates(m_lvl, m_to, m_blank);
         check(gate_o === e, "R8 model compare", gate_o, e);
         check(!(gate_o[0] && gate_o[2]) && !(gate_o[1] && gate_o[3]),
               "R4 pair exclusion", gate_o, 4'b0000);
      end
   end

   task automatic measure(input logic [3:0] pat, output int n);
      int guard = 0;
      n = 0;
      while (gate_o !== pat && guard < 200) begin @(negedge clk); guard++; end
      while (gate_o === pat && n < 200) begin n++; @(negedge clk); end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int n;
      idle(3);
      check(gate_o === 4'b0000, "R1 reset gates off", gate_o, 4'b0000);
      rst_n = 1'b1;
      idle(6);
      check(gate_o === 4'b0000, "R1 R9 hold while off", gate_o, 4'b0000);

      // first move, then dwell and blank toward high (R3 R7 R6 R2)
      blank_cyc = 8'd4;
      req_state = 2'b01;
      @(negedge clk);
      check(gate_o === 4'b0110, "R3 first move to mid", gate_o, 4'b0110);
      measure(4'b0110, n);
      check_int(n == 4, "R7 mid dwell", n, 4);
      measure(4'b0010, n);
      check_int(n == 4, "R6 blank high side", n, 4);
      check(gate_o === 4'b0011, "R2 high level", gate_o, 4'b0011);
      idle(5);

      // rail to rail (R8 R7 R5)
      req_state = 2'b10;
      measure(4'b0010, n);
      check_int(n == 4, "R5 leave high via S2", n, 4);
      check(gate_o === 4'b0110, "R8 passes mid", gate_o, 4'b0110);
      measure(4'b0110, n);
      check_int(n == 4, "R7 mid dwell in crossing", n, 4);
      measure(4'b0100, n);
      check_int(n == 4, "R5 blank low side", n, 4);
      check(gate_o === 4'b1100, "R2 low level", gate_o, 4'b1100);

      // hold code (R9)
      req_state = 2'b11;
      idle(10);
      check(gate_o === 4'b1100, "R9 hold keeps low", gate_o, 4'b1100);

      // zero count gives one-cycle gap (R6)
      blank_cyc = 8'd0;
      req_state = 2'b00;
      measure(4'b0100, n);
      check_int(n == 1, "R6 zero count window", n, 1);
      check(gate_o === 4'b0110, "R2 mid level", gate_o, 4'b0110);
      idle(3);

      // latched count and reversal mid-window (R6 R10)
      blank_cyc = 8'd6;
      req_state = 2'b01;
      @(negedge clk);
      check(gate_o === 4'b0010, "R5 window opened", gate_o, 4'b0010);
      blank_cyc = 8'd2;
      req_state = 2'b10;
      measure(4'b0010, n);
      check_int(n == 6, "R6 latched window length", n, 6);
      check(gate_o === 4'b0011, "R10 window completes", gate_o, 4'b0011);
      idle(30);
      check(gate_o === 4'b1100, "R8 reaches low after reversal", gate_o, 4'b1100);

      // random traffic against the model
      for (int k = 0; k < 120; k++) begin
         req_state = 2'($urandom_range(0, 3));
         blank_cyc = CNT_W'($urandom_range(0, 7));
         idle($urandom_range(1, 14));
      end

      // reset mid-run (R1)
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(gate_o === 4'b0000, "R1 async reset clears", gate_o, 4'b0000);
      req_state = 2'b11;
      idle(2);
      rst_n = 1'b1;
      idle(4);
      check(gate_o === 4'b0000, "R1 off after second reset", gate_o, 4'b0000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule